// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from a fixed set of sources and tells the CPU core which one to service next. Each source is built as one of two kinds, chosen by a parameter mask. An event source sets a pending flag that is held until it is serviced or cleared. A level source requests service only while its input is high and has no flag.

A source is eligible when it is pending and its enable bit is set. When the global enable is on, the lowest-numbered eligible source wins. The block then raises a one-cycle take strobe and drives that source's vector address. Slot 0 is kept for reset, so source i sits at slot i+1 above the selected base.

The core reports return-from-interrupt, set-enable, clear-enable and instruction-retired events to the block. The block uses them to manage the global enable and to hold off re-entry after a return. A select input moves the vector base from zero to a boot-area base.

Top module: `vpic`

## Requirements
- R1: After reset, gie is 0, every enable bit and flag is 0, and take is low.
- R2: When several sources are eligible, the lowest index is served. vec_addr equals base + (index+1)*SLOT (default SLOT=1).
- R3: A source is taken only while its enable bit and the global enable are both 1. An eligible source with its enable bit at 0 causes no take.
- R4: The cycle after a take, gie reads 0. A reti pulse sets gie to 1 at the next edge, and so does a sei pulse.
- R5: Event sources are bits 0 to 3 by default. A flag is set by a high src_req cycle. It is cleared when its vector is taken, and it is cleared by a flag_clr_we write with a 1 in its bit.
- R6: An event that arrives while its enable bit or gie is 0 stays flagged. It is served in priority order once both enables are 1.
- R7: Level sources are bits 4 to 7 by default. They request only in cycles where src_req is high. A level request that goes away before the enables allow it produces no take, and level bits of flags always read 0.
- R8: After a reti, no take occurs until retired has been seen in a cycle later than the reti cycle. The take may come in the cycle after that.
- R9: A cli pulse blocks take in its own cycle. gie is 0 from the next cycle.
- R10: With boot_sel high, vector addresses are offset by BOOT_BASE (default 12'hC00).
- R11: Setting gie with sei inside a handler allows a nested take, under the same priority rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | N | Request inputs, one per source |
| ien_we | input | 1 | Write strobe for the enable bits |
| ien_wdata | input | N | New enable bits |
| flag_clr_we | input | 1 | Write strobe for flag clearing |
| flag_clr_data | input | N | Write-one-to-clear mask for flags |
| sei | input | 1 | Set global enable |
| cli | input | 1 | Clear global enable, immediate |
| reti | input | 1 | Return from interrupt executed |
| retired | input | 1 | A main-program instruction completed |
| boot_sel | input | 1 | Select boot-area vector base |
| take | output | 1 | Take-interrupt strobe |
| vec_addr | output | AW | Vector address of the winning source |
| gie | output | 1 | Global enable state |
| flags | output | N | Pending flags (event sources only) |
| ien | output | N | Enable bits |

## Verification
Several things can land in the same cycle: a cli against a winning request, a reti against a pending flag, and a new event against a hardware or software clear of the same flag. Directed sequences put a cli on the same cycle as a level request. They also put a reti with pending flags ahead of the first retired pulse. Random stimulus then mixes all control pulses with sparse requests. Every cycle, take, vec_addr, gie and flags are compared against a bench model in which a new event beats a clear and a take beats a reti.

// File: rtl/vpic.sv
module vpic #(
  parameter int N = 8,
  parameter int AW = 12,
  parameter int SLOT = 1,
  parameter logic [AW-1:0] BOOT_BASE = 12'hC00,
  parameter logic [N-1:0] FLAGGED = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_req,
  input  logic          ien_we,
  input  logic [N-1:0]  ien_wdata,
  input  logic          flag_clr_we,
  input  logic [N-1:0]  flag_clr_data,
  input  logic          sei,
  input  logic          cli,
  input  logic          reti,
  input  logic          retired,
  input  logic          boot_sel,
  output logic          take,
  output logic [AW-1:0] vec_addr,
  output logic          gie,
  output logic [N-1:0]  flags,
  output logic [N-1:0]  ien
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  pend, elig, taken_oh, clr_mask;
  logic [IW-1:0] sel_idx;
  logic          hold;

  assign pend = (flags & FLAGGED) | (src_req & ~FLAGGED);
  assign elig = pend & ien;

  always_comb begin
    sel_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (elig[i]) sel_idx = IW'(i);
  end

  assign take     = gie && !hold && !cli && (|elig);
  assign taken_oh = take ? (N'(1) << sel_idx) : '0;
  assign clr_mask = taken_oh | (flag_clr_we ? flag_clr_data : '0);
  assign vec_addr = (boot_sel ? BOOT_BASE : '0) + AW'((32'(sel_idx) + 1) * SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      ien   <= '0;
      gie   <= 1'b0;
      hold  <= 1'b0;
    end else begin
      flags <= ((flags & ~clr_mask) | src_req) & FLAGGED;
      if (ien_we) ien <= ien_wdata;
      if (take || cli)      gie <= 1'b0;
      else if (reti || sei) gie <= 1'b1;
      if (reti)         hold <= 1'b1;
      else if (retired) hold <= 1'b0;
    end
  end
endmodule

module vpic_chk #(
  parameter int N = 8,
  parameter logic [N-1:0] FLAGGED = 8'h0F
) (
  input logic         clk,
  input logic         rst_n,
  input logic         take,
  input logic         gie,
  input logic         cli,
  input logic         reti,
  input logic [N-1:0] ien,
  input logic [N-1:0] flags,
  input logic [N-1:0] src_req
);
  // R3
  take_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> gie && (|(ien & ((flags & FLAGGED) | (src_req & ~FLAGGED)))));
  // R4
  gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);
  // R9
  cli_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cli |-> !take);
  // R8
  reti_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> !take);
  // R7
  level_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~FLAGGED) == '0);
endmodule

bind vpic vpic_chk #(.N(N), .FLAGGED(FLAGGED)) u_vpic_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .gie(gie), .cli(cli), .reti(reti),
  .ien(ien), .flags(flags), .src_req(src_req)
);

// File: tb/tb_vpic.sv
module tb_vpic;
  localparam int N = 8;
  localparam int AW = 12;
  localparam logic [N-1:0] FL = 8'h0F;
  localparam logic [AW-1:0] BOOT = 12'hC00;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_req = '0, ien_wdata = '0, flag_clr_data = '0;
  logic ien_we = 0, flag_clr_we = 0, sei = 0, cli = 0, reti = 0, retired = 0, boot_sel = 0;
  logic take, gie;
  logic [AW-1:0] vec_addr;
  logic [N-1:0] flags, ien;

  int errors = 0, checks = 0, cyc = 0;
  logic [N-1:0] m_flags = '0, m_ien = '0;
  logic m_gie = 0, m_hold = 0;

  vpic dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [N-1:0] m_elig();
    return ((m_flags & FL) | (src_req & ~FL)) & m_ien;
  endfunction

  function automatic int m_idx(input logic [N-1:0] e);
    for (int i = 0; i < N; i++) if (e[i]) return i;
    return 0;
  endfunction

  logic last_take;

  task automatic step(input logic [N-1:0] s, input logic iwe, input logic [N-1:0] iwd,
                      input logic cwe, input logic [N-1:0] cwd, input logic se, input logic cl,
                      input logic rt, input logic rd, input logic bs);
    logic et;
    logic [N-1:0] e, clr;
    int ix;
    @(negedge clk);
    src_req = s; ien_we = iwe; ien_wdata = iwd; flag_clr_we = cwe; flag_clr_data = cwd;
    sei = se; cli = cl; reti = rt; retired = rd; boot_sel = bs;
    #1;
    e = m_elig();
    ix = m_idx(e);
    et = m_gie && !m_hold && !cl && (|e);
    chk(gie, m_gie, "R4 gie");
    chk(flags, m_flags, "R5 flags");
    chk(ien, m_ien, "R3 ien");
    chk(take, et, "R2 take");
    if (et) chk(vec_addr, (bs ? BOOT : 12'h0) + 12'(ix + 1), "R2 vec_addr");
    last_take = take;
    clr = (et ? (N'(1) << ix) : '0) | (cwe ? cwd : '0);
    m_flags = ((m_flags & ~clr) | s) & FL;
    if (iwe) m_ien = iwd;
    if (et || cl) m_gie = 0; else if (rt || se) m_gie = 1;
    if (rt) m_hold = 1; else if (rd) m_hold = 0;
  endtask

  task automatic idle(input logic rd = 0);
    step('0, 0, '0, 0, '0, 0, 0, 0, rd, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(gie, 0, "R1 gie"); chk(flags, 0, "R1 flags");
    chk(ien, 0, "R1 ien"); chk(take, 0, "R1 take");

    step('0, 1, 8'hFF, 0, '0, 0, 0, 0, 0, 0);
    step('0, 0, '0, 0, '0, 1, 0, 0, 0, 0);
    step(8'h0C, 0, '0, 0, '0, 0, 0, 0, 0, 0);
    idle();
    chk(last_take, 1, "R2 take lowest"); chk(vec_addr, 12'h003, "R2 vec");
    idle();
    chk(gie, 0, "R4 gie cleared"); chk(flags, 8'h08, "R5 hw clear");
    step('0, 0, '0, 0, '0, 0, 0, 1, 0, 0);
    idle();
    chk(last_take, 0, "R8 hold after reti"); chk(gie, 1, "R4 reti sets gie");
    idle(1);
    chk(last_take, 0, "R8 still held");
    idle();
    chk(last_take, 1, "R6 pending served"); chk(vec_addr, 12'h004, "R6 vec");
    step(8'h10, 0, '0, 0, '0, 0, 0, 0, 0, 0);
    step('0, 0, '0, 0, '0, 1, 0, 0, 0, 0);
    idle();
    chk(last_take, 0, "R7 level gone"); chk(flags, 0, "R7 no flag");
    step(8'h40, 0, '0, 0, '0, 0, 1, 0, 0, 0);
    chk(last_take, 0, "R9 cli same cycle");
    step(8'h40, 0, '0, 0, '0, 0, 0, 0, 0, 0);
    chk(gie, 0, "R9 gie off");
    step('0, 0, '0, 0, '0, 1, 0, 0, 0, 0);
    step(8'h40, 0, '0, 0, '0, 0, 0, 0, 0, 1);
    chk(last_take, 1, "R10 take"); chk(vec_addr, 12'hC07, "R10 boot base");
    step('0, 0, '0, 0, '0, 1, 0, 0, 0, 0);
    step(8'h02, 0, '0, 0, '0, 0, 0, 0, 0, 0);
    idle();
    chk(last_take, 1, "R11 nested"); chk(vec_addr, 12'h002, "R11 vec");
    step(8'h01, 0, '0, 0, '0, 0, 0, 0, 0, 0);
    step('0, 0, '0, 1, 8'h01, 0, 0, 0, 0, 0);
    idle();
    chk(flags, 0, "R5 write-one clear");
    step('0, 1, 8'h00, 0, '0, 1, 0, 0, 0, 0);
    step(8'h04, 0, '0, 0, '0, 0, 0, 0, 0, 0);
    idle();
    chk(last_take, 0, "R3 ien off"); chk(flags, 8'h04, "R6 kept");
    step('0, 1, 8'hFF, 0, '0, 0, 0, 0, 0, 0);
    idle();
    chk(last_take, 1, "R3 ien on");

    for (int k = 0; k < 4000; k++) begin
      step(N'($urandom & $urandom & $urandom), ($urandom % 20) == 0, N'($urandom),
           ($urandom % 15) == 0, N'($urandom), ($urandom % 10) == 0, ($urandom % 16) == 0,
           ($urandom % 12) == 0, ($urandom % 2) == 0, 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule